// File: doc/BRIEF.md
# Sampling Phase Window Search

This block chooses a receive sampling phase for a high-speed serial link. Once started, it walks a phase index upward from zero to a limit given on an input. For every index it first asks the delay logic to apply that phase and waits for an acknowledge. It then requests a tuning test and takes a pass or fail answer back.

While it sweeps, the block keeps the length and the last index of the longest unbroken run of passing phases. After the last phase it programs the phase at the middle of that run, computed as the run's last index minus half its length with the fraction dropped. It reports completion with a one-cycle done pulse. An absent acknowledge, or a sweep with no passing phase at all, ends the search with an error pulse and a kind code.

Top module: `phase_window_tuner`

## Requirements
- R1: After reset, done, err, cfg_req and test_req are low and phase is 0.
- R2: After start in idle, phases 0, 1, ... up to and including max_phase are each applied in increasing order, and exactly one test is run per phase. phase stays steady while cfg_req waits for cfg_ack.
- R3: test_req rises only in the cycle after cfg_ack was accepted, and cfg_req and test_req are never high together.
- R4: A failing test (test_done with test_pass low) clears the current run length and a passing one extends it. A run replaces the best only when it is strictly longer, so on a tie the earlier run wins.
- R5: On success the final phase driven with done equals best_end - best_len/2 (integer division).
- R6: If no phase passes, err pulses with err_kind = 1 and done is not raised.
- R7: If cfg_ack does not arrive within ACK_TIMEOUT cycles of cfg_req, either during the sweep or during final programming, err pulses with err_kind = 0 and the search stops. cfg_req never stays high longer than ACK_TIMEOUT cycles.
- R8: done is high for exactly one cycle, never together with err, and phase then holds the final value until the next start.
- R9: start while a search is running has no effect on the sweep or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (accepted only when idle) |
| max_phase | input | PW | Highest phase index to sweep |
| phase | output | PW | Phase presented to the delay logic |
| cfg_req | output | 1 | Asks the delay logic to apply phase |
| cfg_ack | input | 1 | Delay logic has applied phase |
| test_req | output | 1 | Asks for a tuning test at the current phase |
| test_done | input | 1 | Tuning test finished |
| test_pass | input | 1 | Result of the test, valid with test_done |
| done | output | 1 | One-cycle pulse: final phase applied |
| err | output | 1 | One-cycle pulse: search failed |
| err_kind | output | 1 | 0 = acknowledge timeout, 1 = no passing phase |

## Verification
Some properties are checked on every cycle. The configure and test handshakes must never overlap, and a test may start only right after an acknowledge. The configure wait is bounded by the timeout, phase must stay still during that wait, and done and err are exclusive single-cycle pulses. Other behaviour only the scenarios can show, because the correct answer depends on the whole pass/fail pattern: the ordered sweep, the choice of the longest run with ties going to the earlier one, the centre arithmetic, the no-passing-phase error, timeouts placed at a chosen phase or at final programming, and starts issued mid-search.

// File: rtl/phase_window_tuner.sv
module phase_window_tuner #(
  parameter int PW          = 6,
  parameter int ACK_TIMEOUT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] max_phase,
  output logic [PW-1:0] phase,
  output logic          cfg_req,
  input  logic          cfg_ack,
  output logic          test_req,
  input  logic          test_done,
  input  logic          test_pass,
  output logic          done,
  output logic          err,
  output logic          err_kind
);
  localparam int LW  = PW + 1;
  localparam int TW  = $clog2(ACK_TIMEOUT + 1);

  typedef enum logic [1:0] {S_IDLE, S_CFG, S_TEST} state_t;

  state_t        state;
  logic [PW-1:0] idx;
  logic [LW-1:0] cur_len, best_len;
  logic [PW-1:0] best_end;
  logic          sweep;
  logic [TW-1:0] timer;

  logic [LW-1:0] run_len, new_len;
  logic [PW-1:0] new_end, centre;
  logic          longer, timed_out;

  assign run_len   = test_pass ? cur_len + LW'(1) : '0;
  assign longer    = run_len > best_len;
  assign new_len   = longer ? run_len : best_len;
  assign new_end   = longer ? idx : best_end;
  assign centre    = new_end - PW'(new_len >> 1);
  assign timed_out = (timer == TW'(ACK_TIMEOUT - 1)) && !cfg_ack;

  assign cfg_req   = (state == S_CFG);
  assign test_req  = (state == S_TEST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      idx      <= '0;
      phase    <= '0;
      cur_len  <= '0;
      best_len <= '0;
      best_end <= '0;
      sweep    <= 1'b0;
      timer    <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      err_kind <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          idx      <= '0;
          phase    <= '0;
          cur_len  <= '0;
          best_len <= '0;
          best_end <= '0;
          sweep    <= 1'b1;
          timer    <= '0;
          state    <= S_CFG;
        end
        S_CFG: begin
          timer <= timer + TW'(1);
          if (cfg_ack) begin
            if (sweep) state <= S_TEST;
            else begin
              state <= S_IDLE;
              done  <= 1'b1;
            end
          end else if (timed_out) begin
            state    <= S_IDLE;
            err      <= 1'b1;
            err_kind <= 1'b0;
          end
        end
        S_TEST: if (test_done) begin
          cur_len  <= run_len;
          best_len <= new_len;
          best_end <= new_end;
          timer    <= '0;
          if (idx == max_phase) begin
            sweep <= 1'b0;
            if (new_len == '0) begin
              state    <= S_IDLE;
              err      <= 1'b1;
              err_kind <= 1'b1;
            end else begin
              phase <= centre;
              state <= S_CFG;
            end
          end else begin
            idx   <= idx + PW'(1);
            phase <= idx + PW'(1);
            state <= S_CFG;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module phase_window_tuner_chk #(
  parameter int PW          = 6,
  parameter int ACK_TIMEOUT = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] phase,
  input logic          cfg_req,
  input logic          cfg_ack,
  input logic          test_req,
  input logic          done,
  input logic          err
);
  localparam int CW = $clog2(ACK_TIMEOUT + 2) + 1;
  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_cnt <= '0;
    else if (cfg_req && !cfg_ack) wait_cnt <= wait_cnt + CW'(1);
    else wait_cnt <= '0;
  end

  a_r7_ack_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= CW'(ACK_TIMEOUT));
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req && test_req));
  a_r3_test_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_req) |-> $past(cfg_ack));
  a_r2_phase_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_ack) |=> $stable(phase));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  a_r6_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
endmodule

bind phase_window_tuner phase_window_tuner_chk #(.PW(PW), .ACK_TIMEOUT(ACK_TIMEOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .cfg_req(cfg_req), .cfg_ack(cfg_ack),
  .test_req(test_req), .done(done), .err(err)
);

// File: tb/phase_window_tuner_test.sv
module phase_window_tuner_test;
  localparam int PW = 6;
  localparam int TO = 16;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, start = 0;
  logic [PW-1:0] max_phase = '0;
  logic [PW-1:0] phase;
  logic cfg_req, cfg_ack = 0, test_req, test_done = 0, test_pass = 0;
  logic done, err, err_kind;

  phase_window_tuner #(.PW(PW), .ACK_TIMEOUT(TO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .max_phase(max_phase), .phase(phase),
    .cfg_req(cfg_req), .cfg_ack(cfg_ack), .test_req(test_req), .test_done(test_done),
    .test_pass(test_pass), .done(done), .err(err), .err_kind(err_kind));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { bit is_err; bit kind; int ph; string req; } exp_t;
  exp_t sb[$];

  int n_chk = 0, n_bad = 0, cycles = 0;
  logic [63:0] pattern = '0;
  int withhold_phase = -1;
  bit withhold_final = 0;
  int tests_seen = 0;
  bit seq_ok = 1;
  bit finished = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // card / delay-line model
  initial begin
    int dly = 0, tdly = 0;
    forever begin
      @(negedge clk);
      cfg_ack = 0; test_done = 0; test_pass = 0;
      if (cfg_req) begin
        bit hold;
        hold = (tests_seen <= int'(max_phase)) ? (withhold_phase == tests_seen) : withhold_final;
        if (!hold) begin
          if (dly >= int'(phase) % 3) begin cfg_ack = 1; dly = 0; end
          else dly++;
        end
      end else dly = 0;
      if (test_req) begin
        if (tdly == 1) begin
          test_done = 1;
          test_pass = pattern[phase];
          if (int'(phase) != tests_seen) seq_ok = 0;
          tests_seen++;
          tdly = 0;
        end else tdly++;
      end else tdly = 0;
    end
  end

  // monitor
  always @(negedge clk) begin
    cycles++;
    if (done || err) begin
      if (sb.size() == 0) chk(0, "R8", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(err == e.is_err, e.req, err, e.is_err);
        if (e.is_err) chk(err_kind == e.kind, e.req, err_kind, e.kind);
        else chk(int'(phase) == e.ph, e.req, phase, e.ph);
      end
      finished = 1;
    end
  end

  function automatic int centre_of(logic [63:0] pat, int mp);
    int cur = 0, bl = 0, be = 0;
    for (int i = 0; i <= mp; i++) begin
      cur = pat[i] ? cur + 1 : 0;
      if (cur > bl) begin bl = cur; be = i; end
    end
    return (bl == 0) ? -1 : be - bl / 2;
  endfunction

  task automatic run_case(logic [63:0] pat, int mp, int wp, bit wf, bit restart, string req);
    exp_t e;
    int c;
    pattern = pat; max_phase = PW'(mp); withhold_phase = wp; withhold_final = wf;
    tests_seen = 0; seq_ok = 1; finished = 0;
    c = centre_of(pat, mp);
    e.req = req; e.ph = c;
    if (wp >= 0 || wf) begin e.is_err = 1; e.kind = 0; end
    else if (c < 0) begin e.is_err = 1; e.kind = 1; end
    else e.is_err = 0;
    sb.push_back(e);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (restart) begin
      repeat (5) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    while (!finished) @(negedge clk);
    if (wp < 0) chk(seq_ok && tests_seen == mp + 1, "R2", tests_seen, mp + 1);
    else chk(tests_seen == wp, "R7", tests_seen, wp);
    repeat (3) @(negedge clk);
    chk(!done && !err, "R8", done, 0);
    if (!e.is_err) chk(int'(phase) == c, "R8", phase, c);
    chk(!cfg_req && !test_req, "R7", cfg_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !err && !cfg_req && !test_req && phase == 0, "R1", phase, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !err && !cfg_req && !test_req && phase == 0, "R1", phase, 0);
    run_case(64'hFF, 7, -1, 0, 0, "R5");                      // all pass -> 3
    run_case(64'h3C, 7, -1, 0, 0, "R5");                      // 2..5 -> 3
    run_case(64'h66, 7, -1, 0, 0, "R4");                      // tie -> 1
    run_case(64'hF9, 7, -1, 0, 0, "R4");                      // later longer -> 5
    run_case(64'h00, 7, -1, 0, 0, "R6");                      // no point
    run_case(64'h01, 0, -1, 0, 0, "R5");                      // single -> 0
    run_case(64'h0000_01FF_FFFF_FC00, 63, -1, 0, 0, "R5");    // 10..40 -> 25
    run_case(64'hFF, 7, 3, 0, 0, "R7");                       // sweep timeout
    run_case(64'h3C, 7, -1, 1, 0, "R7");                      // final timeout
    run_case(64'h3C, 7, -1, 0, 1, "R9");                      // restart ignored
    run_case(64'hA5, 7, -1, 0, 0, "R4");                      // runs of 1 -> 0
    chk(sb.size() == 0, "R8", sb.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected 0", cycles);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule